// File: doc/BRIEF.md
# Thread Block Residency Scheduler

This block decides whether a new thread block may become resident on a compute unit. Each request carries the block's thread count, its shared memory footprint in kilobytes and its register count per thread. From these the block derives the warp count and the register file demand. It admits the block only when every resource still fits after the addition: threads, warps, shared memory, registers and a table of resident block slots. An admitted block receives a slot index, and later returns its resources by pulsing completion with that index.

For the request on its inputs, the block also reports the largest number of such blocks that could ever be co-resident. This figure is the smallest of the ceilings set by each resource. It reports the current resident block count as well, and an occupancy percentage: the resident threads as a share of the thread limit, truncated.

Top module: `rs_residency_sched`

## Requirements
- R1: After reset no block is resident, `resident_blocks` and `occupancy` are 0 and `grant` is low.
- R2: The warp demand of a request is its thread count divided by 32 and rounded up. A block of 33 threads therefore costs 2 warps.
- R3: `max_blocks` is the minimum of five ceilings: the slot count (32), 2048 divided by the threads, 64 divided by the warps, 96 divided by the shared memory in KB, and 65536 divided by the registers. The register demand is warps × 32 × registers per thread. A ceiling whose demand is zero does not constrain the result. A zero thread count gives 0.
- R4: `grant` is high in a cycle only if `req_valid` is high, a slot is free, and resident usage plus the request stays at or below every limit. Otherwise `grant` stays low and the request simply waits.
- R5: A granted block receives the lowest-numbered free slot on `grant_slot`.
- R6: A grant, with no completion in the same cycle, raises `resident_blocks` by one in the following cycle.
- R7: A completion pulse on a busy slot frees its slot and its resources in the same cycle it arrives. A request in that cycle is judged against the reduced usage and may take the freed slot.
- R8: A completion pulse naming a slot that holds no block is ignored: no count, usage or admission changes.
- R9: `occupancy` equals floor(100 × resident threads / 2048) as a 7-bit value.
- R10: A request with zero threads is never granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Admission request present; held until granted |
| req_threads | input | 11 | Threads in the requested block (0..1024) |
| req_smem_kb | input | 7 | Shared memory of the block in KB |
| req_regs | input | 8 | Registers per thread |
| grant | output | 1 | Request admitted this cycle |
| grant_slot | output | 5 | Slot index given to the admitted block |
| max_blocks | output | 6 | Co-residency ceiling for the current request |
| done_valid | input | 1 | Completion pulse |
| done_slot | input | 5 | Slot of the completing block |
| resident_blocks | output | 6 | Number of resident blocks |
| occupancy | output | 7 | Resident thread percentage, truncated |

## Verification
`max_blocks`, `grant` and `grant_slot` are combinational on the request, completion inputs and current state. The bench reads them one time step after it drives the inputs on the falling edge, within the same cycle. `resident_blocks` and `occupancy` come from registers, so their values appear one cycle after the grant or completion that moves them. The bench reads them on the falling edge that follows that rising edge. The ceiling is swept over a grid of thread, shared memory and register values, with the expected minimum worked out arithmetically. Fill runs are made until admission stops, and the number of blocks admitted must match the computed ceiling.

// File: rtl/rs_pkg.sv
package rs_pkg;
  parameter int unsigned ACC_W = 20;

  typedef struct packed {
    logic [ACC_W-1:0] threads;
    logic [ACC_W-1:0] warps;
    logic [ACC_W-1:0] smem;
    logic [ACC_W-1:0] regs;
  } demand_t;
endpackage

// File: rtl/rs_demand.sv
module rs_demand
  import rs_pkg::*;
#(
  parameter int unsigned WARP_SIZE = 32,
  parameter int unsigned TW        = 11,
  parameter int unsigned SW        = 7,
  parameter int unsigned RW        = 8
) (
  input  logic [TW-1:0] threads,
  input  logic [SW-1:0] smem_kb,
  input  logic [RW-1:0] regs_per_thread,
  output demand_t       dem
);
  localparam int unsigned WS = WARP_SIZE;

  logic [ACC_W-1:0] thr_ext;
  logic [ACC_W-1:0] warps;

  always_comb begin
    thr_ext     = ACC_W'(threads);
    warps       = (thr_ext + ACC_W'(WS - 1)) / ACC_W'(WS);
    dem.threads = thr_ext;
    dem.warps   = warps;
    dem.smem    = ACC_W'(smem_kb);
    dem.regs    = warps * ACC_W'(WS) * ACC_W'(regs_per_thread);
  end
endmodule

// File: rtl/rs_ceiling.sv
module rs_ceiling
  import rs_pkg::*;
#(
  parameter int unsigned MAX_THREADS = 2048,
  parameter int unsigned MAX_WARPS   = 64,
  parameter int unsigned SMEM_KB     = 96,
  parameter int unsigned REG_FILE    = 65536,
  parameter int unsigned MAX_SLOTS   = 32,
  parameter int unsigned CNT_W       = 6
) (
  input  demand_t          dem,
  output logic [CNT_W-1:0] max_blocks
);
  localparam int unsigned NLIM = 4;

  logic [ACC_W-1:0] limit_v [NLIM];
  logic [ACC_W-1:0] need_v  [NLIM];
  logic [ACC_W-1:0] quot_v  [NLIM];
  logic [ACC_W-1:0] best;

  always_comb begin
    limit_v[0] = ACC_W'(MAX_THREADS);
    limit_v[1] = ACC_W'(MAX_WARPS);
    limit_v[2] = ACC_W'(SMEM_KB);
    limit_v[3] = ACC_W'(REG_FILE);
    need_v[0]  = dem.threads;
    need_v[1]  = dem.warps;
    need_v[2]  = dem.smem;
    need_v[3]  = dem.regs;
  end

  for (genvar g = 0; g < NLIM; g++) begin : g_div
    always_comb begin
      if (need_v[g] == '0) quot_v[g] = ACC_W'(MAX_SLOTS);
      else                 quot_v[g] = limit_v[g] / need_v[g];
    end
  end

  always_comb begin
    best = ACC_W'(MAX_SLOTS);
    for (int i = 0; i < NLIM; i++) begin
      if (quot_v[i] < best) best = quot_v[i];
    end
    if (dem.threads == '0) best = '0;
    max_blocks = CNT_W'(best);
  end
endmodule

// File: rtl/rs_slot_table.sv
module rs_slot_table
  import rs_pkg::*;
#(
  parameter int unsigned MAX_SLOTS = 32,
  parameter int unsigned SLOT_W    = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_en,
  input  logic [SLOT_W-1:0] alloc_slot,
  input  demand_t           alloc_dem,
  input  logic              free_en,
  input  logic [SLOT_W-1:0] free_slot,
  output logic              free_hit,
  output demand_t           free_dem,
  output logic              pick_ok,
  output logic [SLOT_W-1:0] pick_slot,
  output logic [MAX_SLOTS-1:0] busy
);
  logic [MAX_SLOTS-1:0] busy_d;
  logic [MAX_SLOTS-1:0] avail;
  logic [MAX_SLOTS-1:0] free_oh;
  demand_t              store_q [MAX_SLOTS];

  always_comb begin
    free_oh = '0;
    if (free_en && (32'(free_slot) < MAX_SLOTS)) free_oh[free_slot] = 1'b1;
    free_hit = |(free_oh & busy);
    free_dem = '0;
    for (int i = 0; i < MAX_SLOTS; i++) begin
      if (free_oh[i] && busy[i]) free_dem = store_q[i];
    end
  end

  always_comb begin
    avail     = ~busy | (free_oh & busy);
    pick_ok   = |avail;
    pick_slot = '0;
    for (int i = MAX_SLOTS - 1; i >= 0; i--) begin
      if (avail[i]) pick_slot = SLOT_W'(i);
    end
  end

  always_comb begin
    busy_d = busy & ~free_oh;
    if (alloc_en) busy_d[alloc_slot] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy <= '0;
    else if (alloc_en || free_hit) busy <= busy_d;
  end

  for (genvar s = 0; s < MAX_SLOTS; s++) begin : g_store
    logic wr_en;
    assign wr_en = alloc_en && (alloc_slot == SLOT_W'(s));
    always_ff @(posedge clk) begin
      if (wr_en) store_q[s] <= alloc_dem;
    end
  end
endmodule

// File: rtl/rs_residency_sched.sv
module rs_residency_sched
  import rs_pkg::*;
#(
  parameter int unsigned MAX_THREADS       = 2048,
  parameter int unsigned MAX_WARPS         = 64,
  parameter int unsigned SMEM_KB           = 96,
  parameter int unsigned REG_FILE          = 65536,
  parameter int unsigned MAX_SLOTS         = 32,
  parameter int unsigned WARP_SIZE         = 32,
  parameter int unsigned MAX_BLOCK_THREADS = 1024,
  parameter int unsigned RW                = 8,
  localparam int unsigned TW     = $clog2(MAX_BLOCK_THREADS + 1),
  localparam int unsigned SW     = $clog2(SMEM_KB + 1),
  localparam int unsigned SLOT_W = $clog2(MAX_SLOTS),
  localparam int unsigned CNT_W  = $clog2(MAX_SLOTS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [TW-1:0]     req_threads,
  input  logic [SW-1:0]     req_smem_kb,
  input  logic [RW-1:0]     req_regs,
  output logic              grant,
  output logic [SLOT_W-1:0] grant_slot,
  output logic [CNT_W-1:0]  max_blocks,
  input  logic              done_valid,
  input  logic [SLOT_W-1:0] done_slot,
  output logic [CNT_W-1:0]  resident_blocks,
  output logic [6:0]        occupancy
);
  demand_t              req_dem;
  demand_t              rel_dem;
  demand_t              avail_use;
  demand_t              use_d;
  demand_t              use_q;
  logic                 rel_hit;
  logic                 slot_ok;
  logic [SLOT_W-1:0]    slot_pick;
  logic [MAX_SLOTS-1:0] busy;
  logic                 fits;
  logic                 use_en;
  logic [ACC_W+6:0]     occ_wide;

  rs_demand #(
    .WARP_SIZE(WARP_SIZE), .TW(TW), .SW(SW), .RW(RW)
  ) u_demand (
    .threads(req_threads), .smem_kb(req_smem_kb),
    .regs_per_thread(req_regs), .dem(req_dem)
  );

  rs_ceiling #(
    .MAX_THREADS(MAX_THREADS), .MAX_WARPS(MAX_WARPS), .SMEM_KB(SMEM_KB),
    .REG_FILE(REG_FILE), .MAX_SLOTS(MAX_SLOTS), .CNT_W(CNT_W)
  ) u_ceiling (
    .dem(req_dem), .max_blocks(max_blocks)
  );

  rs_slot_table #(
    .MAX_SLOTS(MAX_SLOTS), .SLOT_W(SLOT_W)
  ) u_slots (
    .clk(clk), .rst_n(rst_n),
    .alloc_en(grant), .alloc_slot(slot_pick), .alloc_dem(req_dem),
    .free_en(done_valid), .free_slot(done_slot),
    .free_hit(rel_hit), .free_dem(rel_dem),
    .pick_ok(slot_ok), .pick_slot(slot_pick), .busy(busy)
  );

  // usage as seen by admission this cycle, completion already returned
  always_comb begin
    avail_use.threads = use_q.threads - rel_dem.threads;
    avail_use.warps   = use_q.warps   - rel_dem.warps;
    avail_use.smem    = use_q.smem    - rel_dem.smem;
    avail_use.regs    = use_q.regs    - rel_dem.regs;
  end

  always_comb begin
    fits = (avail_use.threads + req_dem.threads <= ACC_W'(MAX_THREADS))
        && (avail_use.warps   + req_dem.warps   <= ACC_W'(MAX_WARPS))
        && (avail_use.smem    + req_dem.smem    <= ACC_W'(SMEM_KB))
        && (avail_use.regs    + req_dem.regs    <= ACC_W'(REG_FILE));
    grant      = req_valid && (req_dem.threads != '0) && slot_ok && fits;
    grant_slot = slot_pick;
  end

  always_comb begin
    use_d = avail_use;
    if (grant) begin
      use_d.threads = avail_use.threads + req_dem.threads;
      use_d.warps   = avail_use.warps   + req_dem.warps;
      use_d.smem    = avail_use.smem    + req_dem.smem;
      use_d.regs    = avail_use.regs    + req_dem.regs;
    end
    use_en = grant || rel_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) use_q <= '0;
    else if (use_en) use_q <= use_d;
  end

  always_comb begin
    resident_blocks = CNT_W'($countones(busy));
    occ_wide        = ((ACC_W+7)'(use_q.threads) * (ACC_W+7)'(100))
                      / (ACC_W+7)'(MAX_THREADS);
    occupancy       = occ_wide[6:0];
  end
endmodule

// File: rtl/rs_residency_chk.sv
module rs_residency_chk #(
  parameter int unsigned MAX_SLOTS = 32,
  parameter int unsigned TW        = 11,
  parameter int unsigned SLOT_W    = 5,
  parameter int unsigned CNT_W     = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [TW-1:0]     req_threads,
  input logic              grant,
  input logic [SLOT_W-1:0] grant_slot,
  input logic [CNT_W-1:0]  max_blocks,
  input logic              done_valid,
  input logic [CNT_W-1:0]  resident_blocks,
  input logic [6:0]        occupancy
);
  // R4
  grant_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> req_valid);

  // R10
  zero_thr_no_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_threads == '0) |-> !grant);

  // R3
  ceiling_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(max_blocks) <= MAX_SLOTS);

  // R6
  resident_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && !done_valid) |=> (32'(resident_blocks) == 32'($past(resident_blocks)) + 1));

  // R8
  resident_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!grant && !done_valid) |=> $stable(resident_blocks));

  // R9
  occ_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occupancy <= 7'd100);

  // R5
  slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> (32'(grant_slot) < MAX_SLOTS));
endmodule

bind rs_residency_sched rs_residency_chk #(
  .MAX_SLOTS(MAX_SLOTS), .TW(TW), .SLOT_W(SLOT_W), .CNT_W(CNT_W)
) i_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_threads(req_threads),
  .grant(grant), .grant_slot(grant_slot), .max_blocks(max_blocks),
  .done_valid(done_valid), .resident_blocks(resident_blocks),
  .occupancy(occupancy)
);

// File: tb/test_rs_residency_sched.sv
module test_rs_residency_sched;
  localparam int PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [10:0] req_threads;
  logic [6:0]  req_smem_kb;
  logic [7:0]  req_regs;
  logic        grant;
  logic [4:0]  grant_slot;
  logic [5:0]  max_blocks;
  logic        done_valid;
  logic [4:0]  done_slot;
  logic [5:0]  resident_blocks;
  logic [6:0]  occupancy;

  int checks = 0;
  int errors = 0;
  bit ended  = 0;
  int slots_q [40];

  rs_residency_sched i_rs_residency_sched (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_threads(req_threads),
    .req_smem_kb(req_smem_kb), .req_regs(req_regs), .grant(grant),
    .grant_slot(grant_slot), .max_blocks(max_blocks), .done_valid(done_valid),
    .done_slot(done_slot), .resident_blocks(resident_blocks),
    .occupancy(occupancy)
  );

  initial clk = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int min2(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  function automatic int exp_max(input int thr, input int smem, input int rpt);
    int w, r, m;
    if (thr == 0) return 0;
    w = (thr + 31) / 32;
    r = w * 32 * rpt;
    m = min2(32, 2048 / thr);
    m = min2(m, 64 / w);
    if (smem != 0) m = min2(m, 96 / smem);
    if (r != 0) m = min2(m, 65536 / r);
    return m;
  endfunction

  task automatic fill(input int thr, input int smem, input int rpt, output int n);
    n = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      req_valid = 1'b1; req_threads = 11'(thr); req_smem_kb = 7'(smem); req_regs = 8'(rpt);
      #1;
      if (!grant) break;
      // R5: empty table fills from slot 0 upward
      chk(int'(grant_slot) == n, "R5 lowest free slot", int'(grant_slot), n);
      slots_q[n] = int'(grant_slot);
      n++;
      @(posedge clk);
    end
    req_valid = 1'b0;
    #1;
    // R4: admission stops exactly at the ceiling
    chk(n == exp_max(thr, smem, rpt), "R4 blocks admitted", n, exp_max(thr, smem, rpt));
    chk(int'(resident_blocks) == n, "R6 resident count", int'(resident_blocks), n);
    chk(int'(occupancy) == n * thr * 100 / 2048, "R9 occupancy",
        int'(occupancy), n * thr * 100 / 2048);
  endtask

  task automatic release_all(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      done_valid = 1'b1; done_slot = 5'(slots_q[i]);
      @(negedge clk);
      done_valid = 1'b0;
    end
    #1;
    chk(resident_blocks == 6'd0, "R7 all released", int'(resident_blocks), 0);
    chk(occupancy == 7'd0, "R9 empty occupancy", int'(occupancy), 0);
  endtask

  initial begin
    #(PERIOD * 100000);
    if (!ended) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    int thr_l [10] = '{1, 31, 32, 33, 64, 100, 256, 512, 1000, 1024};
    int smm_l [5]  = '{0, 1, 24, 48, 96};
    int rpt_l [5]  = '{0, 16, 32, 64, 255};
    rst_n = 1'b0; req_valid = 1'b0; req_threads = '0; req_smem_kb = '0;
    req_regs = '0; done_valid = 1'b0; done_slot = '0;
    #(PERIOD * 3);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1
    chk(resident_blocks == 6'd0, "R1 reset resident", int'(resident_blocks), 0);
    chk(occupancy == 7'd0, "R1 reset occupancy", int'(occupancy), 0);
    chk(grant == 1'b0, "R1 reset grant", int'(grant), 0);

    // R3 and R2: ceiling sweep
    for (int a = 0; a < 10; a++)
      for (int b = 0; b < 5; b++)
        for (int c = 0; c < 5; c++) begin
          @(negedge clk);
          req_threads = 11'(thr_l[a]); req_smem_kb = 7'(smm_l[b]); req_regs = 8'(rpt_l[c]);
          #1;
          chk(int'(max_blocks) == exp_max(thr_l[a], smm_l[b], rpt_l[c]), "R3 ceiling",
              int'(max_blocks), exp_max(thr_l[a], smm_l[b], rpt_l[c]));
        end
    @(negedge clk);
    req_threads = 11'd0; #1;
    chk(max_blocks == 6'd0, "R3 zero threads", int'(max_blocks), 0);

    // R10: zero thread request never granted
    req_valid = 1'b1; #1;
    chk(grant == 1'b0, "R10 zero thread grant", int'(grant), 0);
    @(negedge clk); req_valid = 1'b0; #1;
    chk(resident_blocks == 6'd0, "R10 no residency", int'(resident_blocks), 0);

    // R2: 33 threads cost 2 warps, so the warp ceiling gives 32 blocks
    fill(33, 0, 0, n);
    chk(n == 32, "R2 warp rounding", n, 32);
    release_all(n);

    // shared memory limited: 48 KB -> 2 blocks, 25 percent
    fill(256, 48, 32, n);
    release_all(n);
    // register limited: 1024 x 64 -> 1 block
    fill(1024, 0, 64, n);
    release_all(n);

    // shared memory limited 24 KB -> 4 blocks, 50 percent
    fill(256, 24, 32, n);
    // R8: completion on idle slot 20 changes nothing
    @(negedge clk);
    done_valid = 1'b1; done_slot = 5'd20; req_valid = 1'b1;
    #1;
    chk(grant == 1'b0, "R8 idle release admits nothing", int'(grant), 0);
    @(negedge clk);
    done_valid = 1'b0; req_valid = 1'b0; #1;
    chk(resident_blocks == 6'd4, "R8 resident unchanged", int'(resident_blocks), 4);
    chk(occupancy == 7'd50, "R8 occupancy unchanged", int'(occupancy), 50);

    // R7: release of slot 2 and request in the same cycle
    @(negedge clk);
    done_valid = 1'b1; done_slot = 5'd2; req_valid = 1'b1;
    #1;
    chk(grant == 1'b1, "R7 same-cycle reuse", int'(grant), 1);
    chk(grant_slot == 5'd2, "R5 reuse freed slot", int'(grant_slot), 2);
    @(negedge clk);
    done_valid = 1'b0; req_valid = 1'b0; #1;
    chk(resident_blocks == 6'd4, "R7 resident after swap", int'(resident_blocks), 4);
    release_all(4);

    ended = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule